// File: doc/BRIEF.md
# Modified DPSK Burst Modulator

This block turns a 10-bit frame word into a single burst of line symbols for a ping-pong transceiver. On a 4.096 MHz clock it produces a 256 kHz carrier in which a 1 bit keeps the carrier's phase and a 0 bit reverses it. The reversal is not an abrupt cusp. It is one smooth 128 kHz half-cycle that lasts a whole bit. An extra 256 kHz half-cycle opens and closes every burst, so a receiver can find the bit boundaries without any preamble bits.

The line drive is a three-level code: idle midpoint, positive or negative. A one-clock start strobe loads the word, and the bits go out MSB first. While the burst runs, `busy` is high. A one-clock `done` pulse follows the closing half-cycle. With loopback set, the symbol stream leaves on a separate loop port and the line drive stays idle. The order of the fields inside the word is set outside this block.

Top module: `mdpsk_modulator`

## Requirements
- R1: After reset, and whenever no burst is running, `line_code` and `loop_code` are idle (2'b00), and `busy` and `done` are low.
- R2: The burst starts in the first cycle after a start strobe is accepted. It opens with a positive (2'b01) half-cycle of HALF clocks (8 by default).
- R3: A 1 bit lasts 2*HALF clocks. It is two HALF-clock half-cycles. The first has the opposite polarity to the segment before it, and the second flips again.
- R4: A 0 bit is one 2*HALF-clock segment whose polarity is opposite to the segment before it. This is the 128 kHz half-cycle that replaces the phase reversal.
- R5: Exactly NBITS bits (10) are sent, MSB first, each taking 2*HALF clocks.
- R6: A closing half-cycle of HALF clocks follows the last bit, with polarity opposite to the segment before it. `busy` stays high for all 2*HALF*NBITS+2*HALF cycles of the burst (176), and `line_code` is never idle during that time.
- R7: In the cycle after the closing half-cycle, `busy` is low and `done` is high for exactly one cycle.
- R8: A start strobe that arrives while `busy` is high is ignored. The running burst is unchanged, and no second burst follows it.
- R9: With `loopback` high, `line_code` is held idle and `loop_code` carries the symbol stream. With `loopback` low, `loop_code` is idle. Positive is 2'b01 and negative is 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock burst request |
| data | input | NBITS | Frame word, sent MSB first |
| loopback | input | 1 | Route symbols to the loop port and idle the line |
| line_code | output | 2 | Line drive level: 00 idle, 01 positive, 10 negative |
| loop_code | output | 2 | Internal loop copy of the symbol stream |
| busy | output | 1 | High during a burst |
| done | output | 1 | One-clock pulse after the closing half-cycle |

## Verification
The strobe is sampled at clock edge k. The first symbol is visible in the cycle after edge k, and symbol i is visible after edge k+i. The `done` pulse and the falling `busy` are due after edge k+176, and full idle is due after edge k+177. The bench counts clock edges. Each expected item carries the edge number after which it is due, and the monitor compares the outputs only at the falling clock edge of the cycle whose edge count matches that number. This way every symbol, the pulse, and the idle cycles after an ignored strobe are checked in exactly the cycle they are due.

// File: rtl/mdpsk_pkg.sv
package mdpsk_pkg;

    typedef enum logic [1:0] {
        LC_IDLE = 2'b00,
        LC_POS  = 2'b01,
        LC_NEG  = 2'b10
    } line_code_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_BITS,
        ST_CLOSE
    } burst_st_t;

    function automatic line_code_t level_of(input logic positive);
        return positive ? LC_POS : LC_NEG;
    endfunction

endpackage

// File: rtl/mdpsk_burst_ctrl.sv
module mdpsk_burst_ctrl
    import mdpsk_pkg::*;
#(
    parameter int HALF  = 8,
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NBITS-1:0] data,
    output logic             busy,
    output logic             done,
    output logic             load,
    output logic             flip
);
    localparam int CNTW = $clog2(2 * HALF);
    localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [CNTW-1:0] HALF_END = CNTW'(HALF - 1);
    localparam logic [CNTW-1:0] BIT_END  = CNTW'(2 * HALF - 1);
    localparam logic [IDXW-1:0] IDX_LAST = IDXW'(NBITS - 1);

    burst_st_t        st;
    logic [CNTW-1:0]  cnt;
    logic [IDXW-1:0]  idx;
    logic [NBITS-1:0] shreg;
    logic             cur_bit;

    assign cur_bit = shreg[NBITS-1];
    assign busy    = (st != ST_IDLE);
    assign load    = (st == ST_IDLE) && start;
    assign flip    = ((st == ST_OPEN) && (cnt == HALF_END)) ||
                     ((st == ST_BITS) && ((cnt == BIT_END) ||
                                          ((cnt == HALF_END) && cur_bit)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st    <= ST_OPEN;
                        cnt   <= '0;
                        idx   <= '0;
                        shreg <= data;
                    end
                end
                ST_OPEN: begin
                    if (cnt == HALF_END) begin
                        st  <= ST_BITS;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_BITS: begin
                    if (cnt == BIT_END) begin
                        cnt <= '0;
                        if (idx == IDX_LAST) begin
                            st <= ST_CLOSE;
                        end else begin
                            idx   <= idx + 1'b1;
                            shreg <= shreg << 1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == HALF_END) begin
                        st   <= ST_IDLE;
                        cnt  <= '0;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // R7: done lasts one cycle
    p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: a burst only ends together with done
    p_busy_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R8: a strobe mid-burst does not end or restart the burst
    p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && st != ST_CLOSE && start) |=> busy);

    // R5: the bit index never passes the last bit
    p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
        idx <= IDX_LAST);

endmodule

// File: rtl/mdpsk_polarity_gen.sv
module mdpsk_polarity_gen
    import mdpsk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       flip,
    input  logic       busy,
    output logic [1:0] sym
);
    logic pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol <= 1'b1;
        end else if (load) begin
            pol <= 1'b1;
        end else if (flip) begin
            pol <= ~pol;
        end
    end

    assign sym = busy ? level_of(pol) : LC_IDLE;

    // R2: the burst opens positive
    p_open_pos_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (sym == LC_POS));

    // R3/R4: every segment boundary alternates the level
    p_flip_alt_r4: assert property (@(posedge clk) disable iff (rst)
        (flip && busy) |=> (sym != $past(sym)));

endmodule

// File: rtl/mdpsk_line_mux.sv
module mdpsk_line_mux
    import mdpsk_pkg::*;
(
    input  logic [1:0] sym,
    input  logic       loopback,
    output logic [1:0] line_code,
    output logic [1:0] loop_code
);
    always_comb begin
        if (loopback) begin
            line_code = LC_IDLE;
            loop_code = sym;
        end else begin
            line_code = sym;
            loop_code = LC_IDLE;
        end
    end

endmodule

// File: rtl/mdpsk_modulator.sv
module mdpsk_modulator
    import mdpsk_pkg::*;
#(
    parameter int HALF  = 8,
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NBITS-1:0] data,
    input  logic             loopback,
    output logic [1:0]       line_code,
    output logic [1:0]       loop_code,
    output logic             busy,
    output logic             done
);
    logic       load;
    logic       flip;
    logic [1:0] sym;

    mdpsk_burst_ctrl #(.HALF(HALF), .NBITS(NBITS)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .data  (data),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .flip  (flip)
    );

    mdpsk_polarity_gen u_pol (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .flip (flip),
        .busy (busy),
        .sym  (sym)
    );

    mdpsk_line_mux u_mux (
        .sym       (sym),
        .loopback  (loopback),
        .line_code (line_code),
        .loop_code (loop_code)
    );

    // R1: no symbol outside a burst
    p_idle_when_free_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sym == LC_IDLE));

    // R6: never idle inside a burst
    p_active_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (sym != LC_IDLE));

    // R9: looped symbols never reach the line
    p_loop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (loopback && busy) |-> (line_code == LC_IDLE && loop_code != LC_IDLE));

endmodule

// File: tb/test_mdpsk_modulator.sv
module test_mdpsk_modulator;
    localparam int HALF  = 8;
    localparam int NBITS = 10;

    typedef struct {
        int         at;
        logic [1:0] line;
        logic [1:0] loop;
        logic       busy;
        logic       done;
        string      tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             loopback = 1'b0;
    logic [NBITS-1:0] data = '0;
    logic [1:0]       line_code;
    logic [1:0]       loop_code;
    logic             busy;
    logic             done;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   base_at;
    int   tcur;
    exp_t q[$];

    mdpsk_modulator #(.HALF(HALF), .NBITS(NBITS)) i_mdpsk_modulator (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .data      (data),
        .loopback  (loopback),
        .line_code (line_code),
        .loop_code (loop_code),
        .busy      (busy),
        .done      (done)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int at, input logic [1:0] l, input logic [1:0] lp,
                        input logic b, input logic d, input string tag);
        exp_t e;
        e.at = at; e.line = l; e.loop = lp; e.busy = b; e.done = d; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic add_seg(input int n, input logic pol, input logic lb, input string tag);
        logic [1:0] code;
        code = pol ? 2'b01 : 2'b10;
        for (int i = 0; i < n; i++) begin
            push(base_at + tcur, lb ? 2'b00 : code, lb ? code : 2'b00, 1'b1, 1'b0, tag);
            tcur++;
        end
    endtask

    task automatic burst(input logic [NBITS-1:0] w, input logic lb, input logic poke);
        logic pol;
        @(negedge clk);
        base_at  = cyc + 1;
        tcur     = 0;
        start    = 1'b1;
        data     = w;
        loopback = lb;
        pol = 1'b1;
        add_seg(HALF, pol, lb, lb ? "R9 R2" : "R2");
        for (int b = NBITS - 1; b >= 0; b--) begin
            pol = ~pol;
            if (w[b]) begin
                add_seg(HALF, pol, lb, lb ? "R9 R3 R5" : "R3 R5");
                pol = ~pol;
                add_seg(HALF, pol, lb, lb ? "R9 R3 R5" : "R3 R5");
            end else begin
                add_seg(2 * HALF, pol, lb, lb ? "R9 R4 R5" : "R4 R5");
            end
        end
        pol = ~pol;
        add_seg(HALF, pol, lb, lb ? "R9 R6" : "R6");
        push(base_at + tcur, 2'b00, 2'b00, 1'b0, 1'b1, "R7");
        push(base_at + tcur + 1, 2'b00, 2'b00, 1'b0, 1'b0, "R7");
        if (poke) begin
            for (int k = 2; k < 8; k++)
                push(base_at + tcur + k, 2'b00, 2'b00, 1'b0, 1'b0, "R8");
        end
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            data  = ~w;
            @(negedge clk);
            start = 1'b0;
        end
        while (q.size() > 0) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0 && q[0].at <= cyc) begin
                e = q.pop_front();
                checks++;
                if (e.at != cyc || line_code !== e.line || loop_code !== e.loop ||
                    busy !== e.busy || done !== e.done) begin
                    errors++;
                    $display("FAIL %s cyc %0d: line=%b loop=%b busy=%b done=%b expected line=%b loop=%b busy=%b done=%b (due %0d)",
                             e.tag, cyc, line_code, loop_code, busy, done,
                             e.line, e.loop, e.busy, e.done, e.at);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (line_code !== 2'b00 || loop_code !== 2'b00 || busy !== 1'b0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: line=%b loop=%b busy=%b done=%b expected 00 00 0 0",
                     line_code, loop_code, busy, done);
        end
        burst(10'b1111111111, 1'b0, 1'b0);
        burst(10'b0000000000, 1'b0, 1'b0);
        burst(10'b1010011100, 1'b0, 1'b1);
        burst(10'b0110100101, 1'b1, 1'b0);
        burst(10'b1000000001, 1'b0, 1'b0);
        burst(10'b0101010101, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule